// File: doc/BRIEF.md
# Bit Test-and-Modify Unit

This unit carries out the memory-side part of the two bit-test instructions of an 8-bit processor core. One instruction forces chosen bits of a memory byte to 1. The other forces them to 0. The core supplies an effective address, a set/clear selector and the accumulator value. The unit reads the byte at that address. It derives the zero flag from the byte as it was read. It then writes the modified byte back to the same address. A one-cycle strobe marks the write cycle. The Z flag output takes its new value in that same cycle.

The core decodes the opcode before this unit sees it. Opcodes 0x04 and 0x0C are the set forms, in zero-page and absolute addressing. Opcodes 0x14 and 0x1C are the clear forms, in the same two addressings. The selector is therefore the inverse of opcode bit 4. The core spends two cycles fetching the opcode and the operand byte. This unit adds three more, which gives a zero-page instruction five cycles in total.

The unit changes nothing except the addressed byte and Z. The accumulator and every other flag stay outside it and are never touched.

Top module: `bit_rmw_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the unit returns to idle. After that edge, `mem_rd`, `mem_wr` and `done` are 0 and `z_flag` is 0.
- R2: A `start` sampled high while idle latches `eff_addr`, `acc_val` and `op_set`. In the next cycle `mem_rd` is 1 and `mem_addr` carries the latched address.
- R3: The bus data for a read is captured one cycle after `mem_rd`. `mem_wr` is asserted in the cycle after that. `mem_rd` and `mem_wr` are never high in the same cycle, and no write occurs without that earlier read.
- R4: The write goes to the same address that was read.
- R5: With `op_set` = 1 (set form), `mem_wdata` equals the byte read OR the latched accumulator.
- R6: With `op_set` = 0 (clear form), `mem_wdata` equals the byte read AND the inverse of the latched accumulator.
- R7: `z_flag` is 1 exactly when the byte read AND the latched accumulator is zero. The test uses the value before modification. Z changes only in the cycle where `done` is high, and holds at all other times.
- R8: `done` is a single-cycle pulse that coincides with `mem_wr`. It comes three cycles after the accepted `start`.
- R9: `start` pulses during the read and modify cycles are ignored. Changes on `eff_addr`, `acc_val` and `op_set` after acceptance have no effect on the operation in progress.
- R10: A `start` in the `done` cycle is accepted. Its read follows in the very next cycle and sees the byte that was just written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation |
| op_set | input | 1 | 1: set bits, 0: clear bits |
| eff_addr | input | 16 | Effective address of the byte |
| acc_val | input | 8 | Accumulator (bit mask) |
| mem_rdata | input | 8 | Read data, valid one cycle after `mem_rd` |
| mem_addr | output | 16 | Bus address |
| mem_rd | output | 1 | Read request |
| mem_wr | output | 1 | Write request |
| mem_wdata | output | 8 | Write data |
| done | output | 1 | Operation completes this cycle |
| z_flag | output | 1 | Zero flag result |

## Verification
The write-back of one operation and the acceptance of the next can fall in the same cycle. When both use one address, the second read must see the first result. The bench provokes this in two ways: it raises `start` in the `done` cycle on a repeated address, and it holds `start` high for many cycles with random traffic over a few colliding addresses. A behavioural reference with its own copy of memory predicts every bus cycle, each write value and each Z flag. The bench compares that prediction on every clock and checks the final byte of the directed chain.

// File: rtl/bit_rmw_pkg.sv
// Shared types for the bit test-and-modify unit.
package bit_rmw_pkg;
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_READ   = 2'd1,
        PH_MODIFY = 2'd2,
        PH_WRITE  = 2'd3
    } phase_t;

    typedef enum logic {
        OP_CLEAR = 1'b0,
        OP_SET   = 1'b1
    } bitop_t;
endpackage

// File: rtl/bit_rmw_ctrl.sv
// Phase sequencer: idle -> read -> modify -> write.
// Assumes read data arrives one cycle after the read request.
// A start is taken only while idle or in the write cycle.
module bit_rmw_ctrl
    import bit_rmw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic capture,
    output logic rd,
    output logic wr,
    output logic fin
);
    phase_t phase;

    // Advance the phase; the write phase may chain straight into a new read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
        end else begin
            case (phase)
                PH_IDLE:   phase <= start ? PH_READ : PH_IDLE;
                PH_READ:   phase <= PH_MODIFY;
                PH_MODIFY: phase <= PH_WRITE;
                default:   phase <= start ? PH_READ : PH_IDLE;
            endcase
        end
    end

    // Decode phase into strobes.
    always_comb begin
        load    = start && (phase == PH_IDLE || phase == PH_WRITE);
        capture = (phase == PH_MODIFY);
        rd      = (phase == PH_READ);
        wr      = (phase == PH_WRITE);
        fin     = (phase == PH_WRITE);
    end
endmodule

// File: rtl/bit_rmw_merge.sv
// Bitwise merge: forces mask bits to 1 or 0 and tests mask against data.
// Purely combinational; assumes operands are already registered.
module bit_rmw_merge
    import bit_rmw_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] cur_val,
    input  logic [DATA_W-1:0] mask,
    input  bitop_t            op,
    output logic [DATA_W-1:0] new_val,
    output logic              none_hit
);
    // One mux per bit: masked bits take the forced level, others keep data.
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        assign new_val[b] = mask[b] ? (op == OP_SET) : cur_val[b];
    end

    // Zero test on the unmodified value.
    assign none_hit = ~|(cur_val & mask);
endmodule

// File: rtl/bit_rmw_unit.sv
// Top of the bit test-and-modify unit: latches operands at start, reads the
// byte, computes Z and the new byte, writes it back to the same address.
// Assumes a bus with one-cycle read latency and single-cycle writes.
module bit_rmw_unit
    import bit_rmw_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              op_set,
    input  logic [ADDR_W-1:0] eff_addr,
    input  logic [DATA_W-1:0] acc_val,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              done,
    output logic              z_flag
);
    logic              load, capture;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] mask_q, res_q, merged;
    bitop_t            op_q;
    logic              z_q, zero_now;

    bit_rmw_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .load    (load),
        .capture (capture),
        .rd      (mem_rd),
        .wr      (mem_wr),
        .fin     (done)
    );

    bit_rmw_merge #(.DATA_W(DATA_W)) u_merge (
        .cur_val  (mem_rdata),
        .mask     (mask_q),
        .op       (op_q),
        .new_val  (merged),
        .none_hit (zero_now)
    );

    // Hold operands for the whole operation; capture result and Z on read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            mask_q <= '0;
            op_q   <= OP_CLEAR;
            res_q  <= '0;
            z_q    <= 1'b0;
        end else begin
            if (load) begin
                addr_q <= eff_addr;
                mask_q <= acc_val;
                op_q   <= bitop_t'(op_set);
            end
            if (capture) begin
                res_q <= merged;
                z_q   <= zero_now;
            end
        end
    end

    assign mem_addr  = addr_q;
    assign mem_wdata = res_q;
    assign z_flag    = z_q;
endmodule

// File: rtl/bit_rmw_unit_chk.sv
// Protocol checker for bit_rmw_unit, bound to every instance.
module bit_rmw_unit_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              done,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              z_flag
);
    a_r3_no_rd_wr_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));
    a_r3_wr_needs_rd: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> $past(mem_rd, 2));
    a_r9_modify_gap: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> (!mem_rd && !mem_wr));
    a_r4_same_addr: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (mem_addr == $past(mem_addr, 2)));
    a_r8_done_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> mem_wr);
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r7_z_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(z_flag) || done);
    a_r10_chain: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> mem_rd);
endmodule

bind bit_rmw_unit bit_rmw_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .done     (done),
    .mem_addr (mem_addr),
    .z_flag   (z_flag)
);

// File: tb/bit_rmw_unit_test.sv
`timescale 1ns/1ps
module bit_rmw_unit_test;
    logic        clk = 1'b0;
    logic        rst_n, start, op_set;
    logic [15:0] eff_addr;
    logic [7:0]  acc_val;
    logic [7:0]  mem_rdata = 8'h00;
    logic [15:0] mem_addr;
    logic        mem_rd, mem_wr, done, z_flag;
    logic [7:0]  mem_wdata;

    always #2 clk = ~clk;

    bit_rmw_unit uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_set(op_set),
        .eff_addr(eff_addr), .acc_val(acc_val), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .done(done), .z_flag(z_flag)
    );

    int checks = 0, errors = 0, cyc = 0;
    bit cmp_on = 1'b0;

    bit [7:0] bus_mem [int];
    bit [7:0] ref_mem [int];

    function automatic bit [7:0] seed_val(int a);
        return 8'(a ^ (a >> 8) ^ 'h5A);
    endfunction
    function automatic bit [7:0] bus_get(int a);
        return bus_mem.exists(a) ? bus_mem[a] : seed_val(a);
    endfunction
    function automatic bit [7:0] ref_get(int a);
        return ref_mem.exists(a) ? ref_mem[a] : seed_val(a);
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Bus memory: sample requests mid-cycle, act on them at the next edge.
    bit        s_rd = 0, s_wr = 0;
    bit [15:0] s_addr = 0;
    bit [7:0]  s_wdata = 0;
    always @(negedge clk) begin
        s_rd = mem_rd; s_wr = mem_wr; s_addr = mem_addr; s_wdata = mem_wdata;
    end
    always @(posedge clk) begin
        if (s_rd) mem_rdata <= bus_get(int'(s_addr));
        if (s_wr) bus_mem[int'(s_addr)] = s_wdata;
    end

    // Behavioural reference: phase 0 idle, 1 read, 2 modify, 3 write.
    int       ph = 0;
    bit [15:0] r_addr = 0;
    bit [7:0]  r_acc = 0, r_res = 0;
    bit        r_set = 0, r_z = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            ph = 0; r_z = 0;
        end else begin
            case (ph)
                0: if (start) begin ph = 1; r_addr = eff_addr; r_acc = acc_val; r_set = op_set; end
                1: ph = 2;
                2: begin
                    bit [7:0] d;
                    d = ref_get(int'(r_addr));
                    r_z = ((d & r_acc) == 8'h00);
                    r_res = r_set ? (d | r_acc) : (d & ~r_acc);
                    ph = 3;
                end
                default: begin
                    ref_mem[int'(r_addr)] = r_res;
                    if (start) begin ph = 1; r_addr = eff_addr; r_acc = acc_val; r_set = op_set; end
                    else ph = 0;
                end
            endcase
        end
    end

    // Compare every cycle, away from the active edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            chk(mem_rd == (ph == 1), "R2", "mem_rd", mem_rd, ph == 1);
            chk(mem_wr == (ph == 3), "R3", "mem_wr", mem_wr, ph == 3);
            chk(done == (ph == 3), "R8", "done", done, ph == 3);
            chk(z_flag == r_z, "R7", "z_flag", z_flag, r_z);
            if (ph == 1) chk(mem_addr == r_addr, "R2", "read addr", mem_addr, r_addr);
            if (ph == 3) begin
                chk(mem_addr == r_addr, "R4", "write addr", mem_addr, r_addr);
                chk(mem_wdata == r_res, r_set ? "R5" : "R6", "wdata", mem_wdata, r_res);
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected<=20000", cyc);
            finish_run();
        end
    end

    task automatic issue(bit [15:0] a, bit [7:0] m, bit s);
        start = 1'b1; eff_addr = a; acc_val = m; op_set = s;
        @(negedge clk);
    endtask

    initial begin
        bit [7:0] expect_b;
        rst_n = 1'b0; start = 1'b0; op_set = 1'b0; eff_addr = '0; acc_val = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!mem_rd && !mem_wr && !done, "R1", "strobes", {mem_rd, mem_wr, done}, 0);
        chk(z_flag == 1'b0, "R1", "z_flag", z_flag, 0);
        rst_n = 1'b1; cmp_on = 1'b1;
        @(negedge clk);

        // R10 chain with R9 disturbance: set 0x0F, then clear 0x03 on same byte.
        expect_b = (seed_val('h0010) | 8'h0F) & ~8'h03;
        issue(16'h0010, 8'h0F, 1'b1);
        issue(16'h0999, 8'hF0, 1'b0);   // R9: ignored in read cycle
        issue(16'h0777, 8'hAA, 1'b0);   // R9: ignored in modify cycle
        issue(16'h0010, 8'h03, 1'b0);   // R10: accepted in done cycle
        start = 1'b0; eff_addr = 16'h4444; acc_val = 8'hFF; op_set = 1'b1;
        repeat (5) @(negedge clk);
        chk(bus_get('h0010) == expect_b, "R10", "chained byte", bus_get('h0010), expect_b);

        // Corner masks: empty mask (Z=1, byte kept), full mask, page edges.
        issue(16'h00FF, 8'h00, 1'b0); start = 1'b0; repeat (4) @(negedge clk);
        chk(bus_get('h00FF) == seed_val('h00FF), "R6", "empty mask", bus_get('h00FF), seed_val('h00FF));
        issue(16'hFFFF, 8'hFF, 1'b1); start = 1'b0; repeat (4) @(negedge clk);
        chk(bus_get('hFFFF) == 8'hFF, "R5", "full set", bus_get('hFFFF), 8'hFF);
        issue(16'hFFFF, 8'hFF, 1'b0); start = 1'b0; repeat (4) @(negedge clk);
        chk(bus_get('hFFFF) == 8'h00, "R6", "full clear", bus_get('hFFFF), 8'h00);

        // Random traffic over colliding addresses; start often held high.
        for (int i = 0; i < 2000; i++) begin
            int sel;
            sel = $urandom % 4;
            start = ($urandom % 3) != 0;
            eff_addr = (sel == 0) ? 16'h0010 : (sel == 1) ? 16'h0011 :
                       (sel == 2) ? 16'h1234 : 16'($urandom);
            sel = $urandom % 6;
            acc_val = (sel == 0) ? 8'h00 : (sel == 1) ? 8'hFF : 8'($urandom);
            op_set = $urandom % 2;
            @(negedge clk);
        end
        start = 1'b0;
        repeat (6) @(negedge clk);
        foreach (ref_mem[k])
            chk(bus_get(k) == ref_mem[k], "R4", "final byte", bus_get(k), ref_mem[k]);
        finish_run();
    end
endmodule